// File: doc/BRIEF.md
# Parallel EEPROM Host Access Controller

This block sits on the host side of an asynchronous byte-wide EEPROM bus and turns single requests from a valid/ready interface into correctly timed chip-enable, output-enable and write-enable waveforms. Every timing minimum is a nanosecond parameter that is turned into a whole number of clock cycles at elaboration, rounded up, so the same RTL fits any system clock.

A read request runs one access cycle and returns the byte that was sampled. A write request runs a write-enable controlled byte write and then polls the same address. While the device is still programming, the most significant data bit reads back inverted. Polling continues until that bit matches the written value, or until the maximum write cycle time has passed. In the second case the block reports an error. In both cases it returns to idle.

Top module: `eeprom_host_ctrl`

## Requirements
- R1: During and directly after reset, all three strobes are high, the data drive enable is low, `req_ready` is high, and `rsp_done` and `rsp_error` are low.
- R2: `req_ready` is high only while the controller is idle and no strobe is low. A request held valid while `req_ready` is low is not taken and never reaches the bus.
- R3: Every phase length is ceil(ns / CLK_NS) cycles, minimum 1. A write starts with a setup phase of max(address setup, output-enable setup) cycles (2 at defaults). In this phase chip enable is low, output enable and write enable are high, and address and data are driven.
- R4: Write enable is then low for max(pulse width, address hold, data setup) cycles (15 at defaults). During the pulse chip enable stays low, output enable stays high, and address and data do not change.
- R5: After write enable rises, a hold phase of max(data hold, output-enable hold) cycles (2 at defaults) keeps chip enable low, output enable high and data driven.
- R6: Output enable and write enable are never low together, and the data drive enable is high only while output enable is high.
- R7: After the hold phase, the controller polls the written address. Each poll read has chip and output enable low for max(read cycle, address access, output-enable access) cycles (20 at defaults), followed by a gap of ceil(output-enable setup) cycles with all strobes high. Polling stops when bit 7 of the byte sampled in the last read cycle equals bit 7 of the written byte. `rsp_done` is then a one-cycle pulse with `rsp_error` low and `rsp_rdata` set to that byte.
- R8: A poll sample whose bit 7 still differs, taken after at least ceil(T_WC_NS / CLK_NS) cycles of polling, ends the write with `rsp_done` and `rsp_error` both high for one cycle, and the controller returns to idle. `rsp_error` is never high without `rsp_done`.
- R9: A read request drives chip and output enable low for the read length, starting in the cycle after acceptance. It returns the byte sampled in the last cycle on `rsp_rdata`, with `rsp_done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this cycle if valid |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | AW (11) | Byte address |
| req_wdata | input | DW (8) | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Write timed out (with rsp_done) |
| rsp_rdata | output | DW (8) | Last sampled byte |
| mem_addr | output | AW (11) | Address to the device |
| mem_dout | output | DW (8) | Data toward the device |
| mem_drive | output | 1 | Enable for the host data driver |
| mem_din | input | DW (8) | Data from the device |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach is the timeout. A working device always finishes within a bounded time, so the error path only appears if the device never stops reporting an inverted bit 7. The bench's behavioural device model has a stuck switch that freezes its internal programming countdown. A write issued with the switch set keeps polling until the cycle limit expires, and the bench then checks the error pulse and the latency window. A second case that is hard to reach is a request presented while a write is still polling. The bench raises `req_valid` with a different address in the middle of a poll loop, drops it before completion, and later reads that address to confirm it was never written.

// File: rtl/eeprom_host_pkg.sv
package eeprom_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_PREAD  = 3'd4,
    ST_PGAP   = 3'd5,
    ST_RREAD  = 3'd6
  } ctl_state_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ee_poll_timer.sv
module ee_poll_timer #(
  parameter int LIMIT = 1000,
  parameter int W     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic limit_hit
);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)          cnt <= '0;
    else if (run && cnt < LIM) cnt <= cnt + 1'b1;
  end

  assign limit_hit = (cnt >= LIM);
endmodule

// File: rtl/ee_seq_fsm.sv
module ee_seq_fsm
  import eeprom_host_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int PH_W    = 5,
  parameter int S_CYC   = 2,
  parameter int P_CYC   = 15,
  parameter int H_CYC   = 2,
  parameter int RD_CYC  = 20,
  parameter int GAP_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            rsp_done,
  output logic            rsp_error,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_dout,
  output logic            mem_drive,
  input  logic [DW-1:0]   mem_din,
  output logic            mem_ce_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic            ph_load,
  output logic [PH_W-1:0] ph_val,
  input  logic            ph_expired,
  output logic            to_clear,
  output logic            to_run,
  input  logic            to_hit
);
  ctl_state_e state, nxt;
  logic       accept, finish, fail, capture;
  logic       bit_ok;

  function automatic logic [PH_W-1:0] phase_len(input ctl_state_e s);
    case (s)
      ST_WSETUP: return PH_W'(S_CYC);
      ST_WPULSE: return PH_W'(P_CYC);
      ST_WHOLD:  return PH_W'(H_CYC);
      ST_PREAD:  return PH_W'(RD_CYC);
      ST_PGAP:   return PH_W'(GAP_CYC);
      ST_RREAD:  return PH_W'(RD_CYC);
      default:   return PH_W'(1);
    endcase
  endfunction

  assign bit_ok = (mem_din[DW-1] == mem_dout[DW-1]);

  always_comb begin
    nxt     = state;
    accept  = 1'b0;
    finish  = 1'b0;
    fail    = 1'b0;
    capture = 1'b0;
    case (state)
      ST_IDLE:
        if (req_valid) begin
          accept = 1'b1;
          nxt    = req_write ? ST_WSETUP : ST_RREAD;
        end
      ST_WSETUP: if (ph_expired) nxt = ST_WPULSE;
      ST_WPULSE: if (ph_expired) nxt = ST_WHOLD;
      ST_WHOLD:  if (ph_expired) nxt = ST_PREAD;
      ST_PREAD:
        if (ph_expired) begin
          capture = 1'b1;
          if (bit_ok) begin
            finish = 1'b1;
            nxt    = ST_IDLE;
          end else if (to_hit) begin
            finish = 1'b1;
            fail   = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            nxt = ST_PGAP;
          end
        end
      ST_PGAP:   if (ph_expired) nxt = ST_PREAD;
      ST_RREAD:
        if (ph_expired) begin
          capture = 1'b1;
          finish  = 1'b1;
          nxt     = ST_IDLE;
        end
      default:   nxt = ST_IDLE;
    endcase
  end

  assign ph_load  = (nxt != state) && (nxt != ST_IDLE);
  assign ph_val   = phase_len(nxt) - 1'b1;
  assign to_clear = accept;
  assign to_run   = (state == ST_PREAD) || (state == ST_PGAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_dout  <= '0;
      mem_drive <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
    end else begin
      state     <= nxt;
      req_ready <= (nxt == ST_IDLE);
      rsp_done  <= finish;
      rsp_error <= fail;
      if (capture) rsp_rdata <= mem_din;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      mem_ce_n  <= !(nxt inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_PREAD, ST_RREAD});
      mem_oe_n  <= !(nxt inside {ST_PREAD, ST_RREAD});
      mem_we_n  <= (nxt != ST_WPULSE);
      mem_drive <= (nxt inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
    end
  end
endmodule

// File: rtl/eeprom_host_ctrl.sv
module eeprom_host_ctrl
  import eeprom_host_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AS_NS   = 10,
  parameter int T_AH_NS   = 100,
  parameter int T_WP_NS   = 150,
  parameter int T_DS_NS   = 50,
  parameter int T_DH_NS   = 10,
  parameter int T_OES_NS  = 15,
  parameter int T_OEH_NS  = 15,
  parameter int T_RC_NS   = 200,
  parameter int T_ACC_NS  = 200,
  parameter int T_OEA_NS  = 80,
  parameter int T_WC_NS   = 10000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic          rsp_error,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_drive,
  input  logic [DW-1:0] mem_din,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);
  localparam int S_CYC   = imax2(ns_to_cyc(T_AS_NS, CLK_NS), ns_to_cyc(T_OES_NS, CLK_NS));
  localparam int P_CYC   = imax2(ns_to_cyc(T_WP_NS, CLK_NS),
                                 imax2(ns_to_cyc(T_AH_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)));
  localparam int H_CYC   = imax2(ns_to_cyc(T_DH_NS, CLK_NS), ns_to_cyc(T_OEH_NS, CLK_NS));
  localparam int RD_CYC  = imax2(ns_to_cyc(T_RC_NS, CLK_NS),
                                 imax2(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OEA_NS, CLK_NS)));
  localparam int GAP_CYC = ns_to_cyc(T_OES_NS, CLK_NS);
  localparam int TO_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int PH_MAX  = imax2(imax2(S_CYC, P_CYC), imax2(imax2(H_CYC, RD_CYC), GAP_CYC));
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int TO_W    = $clog2(TO_CYC + 1);

  logic            ph_load, ph_expired;
  logic [PH_W-1:0] ph_val;
  logic            to_clear, to_run, to_hit;

  ee_seq_fsm #(
    .AW(AW), .DW(DW), .PH_W(PH_W),
    .S_CYC(S_CYC), .P_CYC(P_CYC), .H_CYC(H_CYC),
    .RD_CYC(RD_CYC), .GAP_CYC(GAP_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_drive(mem_drive),
    .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .ph_load(ph_load), .ph_val(ph_val), .ph_expired(ph_expired),
    .to_clear(to_clear), .to_run(to_run), .to_hit(to_hit)
  );

  ee_phase_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .expired(ph_expired)
  );

  ee_poll_timer #(.LIMIT(TO_CYC), .W(TO_W)) u_poll_to (
    .clk(clk), .rst(rst), .clear(to_clear), .run(to_run), .limit_hit(to_hit)
  );
endmodule

// File: rtl/eeprom_host_ctrl_chk.sv
module eeprom_host_ctrl_chk
  import eeprom_host_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 150
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          rsp_error,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_drive,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n
);
  localparam int MIN_WP = ns_to_cyc(T_WP_NS, CLK_NS);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)                             low_run <= '0;
    else if (!mem_we_n && low_run != '1) low_run <= low_run + 1'b1;
    else if (mem_we_n)                   low_run <= '0;
  end

  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!mem_oe_n && !mem_we_n));
  // R6
  drive_oe_high_chk: assert property (@(posedge clk) disable iff (rst) mem_drive |-> mem_oe_n);
  // R4
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> (!mem_ce_n && mem_drive));
  // R4
  we_bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));
  // R4
  we_min_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (low_run >= 16'(MIN_WP)));
  // R2
  ready_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_drive));
  // R8
  error_with_done_chk: assert property (@(posedge clk) disable iff (rst) rsp_error |-> rsp_done);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done);
endmodule

bind eeprom_host_ctrl eeprom_host_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done), .rsp_error(rsp_error),
  .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_drive(mem_drive),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
);

// File: tb/test_eeprom_host_ctrl.sv
module test_eeprom_host_ctrl;
  localparam int CLKP    = 10;
  localparam int TWC_NS  = 3000;
  localparam int BUSY    = 60;
  // expected phase lengths, worked out by hand for the default timings at 10 ns
  localparam int NS = 2, NP = 15, NH = 2, NRD = 20, NGAP = 2;
  localparam int NTO = TWC_NS / CLKP;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, rsp_error;
  logic [7:0]  rsp_rdata, mem_dout, mem_din;
  logic [10:0] mem_addr;
  logic        mem_drive, mem_ce_n, mem_oe_n, mem_we_n;

  int checks = 0, failures = 0, cyc = 0;

  always #(CLKP/2) clk = ~clk;

  eeprom_host_ctrl #(.T_WC_NS(TWC_NS)) i_eeprom_host_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_drive(mem_drive), .mem_din(mem_din),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural device ----------------
  logic [7:0]  dev_mem [2048];
  logic        dev_busy = 1'b0, dev_stuck = 1'b0, dev_we_prev = 1'b1;
  int          dev_left = 0;
  logic [10:0] dev_waddr = '0;
  logic [7:0]  dev_wdata = '0;

  initial for (int i = 0; i < 2048; i++) dev_mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    dev_we_prev <= mem_we_n;
    if (!dev_we_prev && mem_we_n && !mem_ce_n) begin
      dev_busy  <= 1'b1;
      dev_left  <= BUSY;
      dev_waddr <= mem_addr;
      dev_wdata <= mem_dout;
    end else if (dev_busy && !dev_stuck) begin
      if (dev_left <= 1) begin
        dev_busy <= 1'b0;
        dev_mem[dev_waddr] <= dev_wdata;
      end else dev_left <= dev_left - 1;
    end
  end

  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_din = (dev_busy && mem_addr == dev_waddr) ? {~dev_wdata[7], 7'h2A} : dev_mem[mem_addr];
    else
      mem_din = 8'h00;
  end

  // ---------------- cycle reference model ----------------
  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit         model_busy = 1'b0;

  task automatic push_n(input int n, input logic [2:0] v, input string t);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_done) model_busy = 1'b0;
      chk(req_ready == !model_busy, "R2 ready", req_ready, !model_busy);
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({mem_ce_n, mem_oe_n, mem_we_n} == e, t, {mem_ce_n, mem_oe_n, mem_we_n}, e);
      end
      if (req_valid && req_ready) begin
        model_busy = 1'b1;
        if (req_write) begin
          push_n(NS,  3'b011, "R3 setup strobes");
          push_n(NP,  3'b010, "R4 pulse strobes");
          push_n(NH,  3'b011, "R5 hold strobes");
          push_n(NRD, 3'b001, "R7 first poll strobes");
        end else begin
          push_n(NRD, 3'b001, "R9 read strobes");
          push_n(1,   3'b111, "R9 idle after read");
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_req(input logic wr, input logic [10:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic er, output int lat,
                        output logic busy_at_done);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_done) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata; er = rsp_error; busy_at_done = dev_busy;
  endtask

  initial begin
    logic [7:0] rd;
    logic       er, bz;
    int         lat;

    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(req_ready && !rsp_done && !rsp_error && !mem_drive, "R1 flags in reset",
        {req_ready, rsp_done, rsp_error, mem_drive}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_drive, "R1 after reset", {req_ready, mem_ce_n, mem_drive}, 3'b110);

    // plain reads
    do_req(1'b0, 11'h000, 8'h00, rd, er, lat, bz);
    chk(rd == 8'h5A, "R9 read addr 0", rd, 8'h5A);
    chk(lat == NRD + 1, "R9 read latency", lat, NRD + 1);
    do_req(1'b0, 11'h7FF, 8'h00, rd, er, lat, bz);
    chk(rd == 8'hA5, "R9 read top addr", rd, 8'hA5);

    // writes with bit 7 set and clear
    do_req(1'b1, 11'h123, 8'hA5, rd, er, lat, bz);
    chk(rd == 8'hA5 && !er, "R7 write A5 result", {er, rd}, 9'h0A5);
    chk(!bz, "R7 device idle at done", bz, 0);
    chk(lat > NS + NP + NH + NRD + NGAP, "R7 polled more than once", lat, NS + NP + NH + NRD + NGAP);
    do_req(1'b0, 11'h123, 8'h00, rd, er, lat, bz);
    chk(rd == 8'hA5, "R9 readback A5", rd, 8'hA5);

    do_req(1'b1, 11'h7FF, 8'h3C, rd, er, lat, bz);
    chk(rd == 8'h3C && !er && !bz, "R7 write 3C result", {er, bz, rd}, 10'h03C);
    do_req(1'b0, 11'h7FF, 8'h00, rd, er, lat, bz);
    chk(rd == 8'h3C, "R9 readback 3C", rd, 8'h3C);

    do_req(1'b1, 11'h000, 8'h80, rd, er, lat, bz);
    chk(rd == 8'h80 && !er, "R7 write 80 result", {er, rd}, 9'h080);

    // stray request while a write is polling
    fork
      do_req(1'b1, 11'h010, 8'h11, rd, er, lat, bz);
      begin
        repeat (30) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h020; req_wdata = 8'hEE;
        repeat (10) @(negedge clk);
        chk(!req_ready, "R2 not ready while polling", req_ready, 0);
        req_valid = 1'b0;
      end
    join
    chk(rd == 8'h11 && !er, "R7 write 11 result", {er, rd}, 9'h011);
    repeat (5) @(negedge clk);
    do_req(1'b0, 11'h020, 8'h00, rd, er, lat, bz);
    chk(rd == (8'h20 ^ 8'h5A), "R2 stray request ignored", rd, 8'h20 ^ 8'h5A);

    // timeout with a device that never finishes
    dev_stuck = 1'b1;
    do_req(1'b1, 11'h055, 8'h7F, rd, er, lat, bz);
    chk(er == 1'b1, "R8 timeout error flag", er, 1);
    chk(lat >= NTO, "R8 timeout not early", lat, NTO);
    chk(lat <= NS + NP + NH + NTO + NRD + NGAP + 2, "R8 timeout not late", lat,
        NS + NP + NH + NTO + NRD + NGAP + 2);
    @(negedge clk);
    chk(!rsp_error && !rsp_done && req_ready, "R8 back to idle", {rsp_error, rsp_done, req_ready}, 1);
    dev_stuck = 1'b0;
    repeat (BUSY + 10) @(negedge clk);
    do_req(1'b0, 11'h055, 8'h00, rd, er, lat, bz);
    chk(rd == 8'h7F && !er, "R9 read after timeout", {er, rd}, 9'h07F);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 model queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule